// File: doc/BRIEF.md
# 64-bit Logical and Sign-Extend Unit

This block is the bitwise slice of a fixed-point integer execute stage. It is purely combinational. It takes two 64-bit source operands, a 16-bit unsigned immediate, a 5-bit operation code and a record flag. From these it forms a 64-bit result and three condition flags. The operations fall into four groups: the register-register boolean forms, including the complemented and equivalence variants; the immediate forms, which use the immediate in the low halfword; the shifted-immediate forms, which place the immediate one halfword higher; and sign extension from byte, halfword or word.

Register access, decode and condition-register writeback all sit outside the block. The surrounding pipeline places operands on the inputs and takes the result within the same cycle. When the instruction is a record form, the pipeline also stores the flag triple.

Top module: `logic_sext_unit`

## Requirements
- R1: Codes 0, 1 and 2 give rs & rb, rs | rb and rs ^ rb.
- R2: Codes 3, 4 and 5 give ~(rs & rb), ~(rs | rb) and ~(rs ^ rb).
- R3: Code 6 gives rs & ~rb, and code 7 gives rs | ~rb.
- R4: Codes 8, 9 and 10 apply AND, OR and XOR between rs and the immediate zero-extended into result bits 15..0, where bit 0 is the least significant bit.
- R5: Codes 11, 12 and 13 apply AND, OR and XOR between rs and an operand that holds the immediate in bits 31..16 and zeros in every other bit.
- R6: Codes 14, 15 and 16 sign-extend rs from its low 8, 16 and 32 bits respectively. Each replicates bit 7, 15 or 31 into all higher bits and keeps the low bits unchanged.
- R7: Codes 17 through 31 give an all-zero result.
- R8: With rec_i high, flags_o is {LT, GT, EQ} in bits 2, 1 and 0, taken from the result read as a signed 64-bit number. Exactly one flag is set.
- R9: With rec_i low, flags_o is zero whatever the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rs_i | input | 64 | First source operand |
| rb_i | input | 64 | Second source operand (register forms) |
| imm_i | input | 16 | Unsigned immediate |
| op_i | input | 5 | Operation code |
| rec_i | input | 1 | Record form: produce condition flags |
| res_o | output | 64 | Result |
| flags_o | output | 3 | {LT, GT, EQ} when recording, else zero |

## Verification
The block holds no state. A wrong decode, a misplaced immediate or a wrong sign-extension width therefore shows on res_o in the same cycle the operands are applied, and nothing hides it for later. A flag fault shows as a flags_o value that breaks one-hot, or that disagrees in sign or zero-ness with res_o. The sweep drives every code, including the unassigned ones, over corner operands whose sign bits, extension bits and immediate halfwords differ. A field that is off by one position therefore changes at least one compared vector.

// File: rtl/logic_sext_pkg.sv
package logic_sext_pkg;

   localparam int OP_W = 5;

   typedef enum logic [OP_W-1:0] {
      OP_AND   = 5'd0,
      OP_OR    = 5'd1,
      OP_XOR   = 5'd2,
      OP_NAND  = 5'd3,
      OP_NOR   = 5'd4,
      OP_EQV   = 5'd5,
      OP_ANDC  = 5'd6,
      OP_ORC   = 5'd7,
      OP_ANDLO = 5'd8,
      OP_ORLO  = 5'd9,
      OP_XORLO = 5'd10,
      OP_ANDHI = 5'd11,
      OP_ORHI  = 5'd12,
      OP_XORHI = 5'd13,
      OP_SXB   = 5'd14,
      OP_SXH   = 5'd15,
      OP_SXW   = 5'd16
   } op_e;

   typedef enum logic [1:0] {
      BASE_AND = 2'd0,
      BASE_OR  = 2'd1,
      BASE_XOR = 2'd2
   } base_e;

   typedef enum logic [1:0] {
      SRC_REG   = 2'd0,
      SRC_IMMLO = 2'd1,
      SRC_IMMHI = 2'd2
   } src_e;

   typedef enum logic [1:0] {
      KIND_NONE  = 2'd0,
      KIND_LOGIC = 2'd1,
      KIND_EXT   = 2'd2
   } kind_e;

   typedef struct packed {
      kind_e       kind;
      base_e       base;
      src_e        src;
      logic        inv_b;
      logic        inv_out;
      logic [1:0]  ext_sel;
   } ctrl_t;

endpackage

// File: rtl/lsx_bool.sv
module lsx_bool
   import logic_sext_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0] a_i,
   input  logic [XLEN-1:0] b_i,
   input  base_e           base_i,
   input  logic            inv_b_i,
   input  logic            inv_out_i,
   output logic [XLEN-1:0] y_o
);

   logic [XLEN-1:0] b_eff;
   logic [XLEN-1:0] core;

   assign b_eff = inv_b_i ? ~b_i : b_i;

   always_comb begin
      unique case (base_i)
         BASE_AND: core = a_i & b_eff;
         BASE_OR:  core = a_i | b_eff;
         BASE_XOR: core = a_i ^ b_eff;
         default:  core = '0;
      endcase
   end

   assign y_o = inv_out_i ? ~core : core;

endmodule

// File: rtl/lsx_sext.sv
module lsx_sext #(
   parameter int XLEN   = 64,
   parameter int FROM_W = 8
) (
   input  logic [FROM_W-1:0] src_i,
   output logic [XLEN-1:0]   y_o
);

   localparam int FILL_W = XLEN - FROM_W;

   if (FROM_W < 1 || FROM_W >= XLEN) begin : g_bad_width
      $error("lsx_sext: FROM_W must lie between 1 and XLEN-1");
   end

   assign y_o = {{FILL_W{src_i[FROM_W-1]}}, src_i};

endmodule

// File: rtl/lsx_flags.sv
module lsx_flags #(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0] res_i,
   input  logic            rec_i,
   output logic [2:0]      flags_o
);

   logic neg;
   logic zero;

   assign neg  = res_i[XLEN-1];
   assign zero = (res_i == '0);

   assign flags_o = rec_i ? {neg, ~neg & ~zero, zero} : 3'b000;

endmodule

// File: rtl/logic_sext_unit.sv
module logic_sext_unit
   import logic_sext_pkg::*;
#(
   parameter int XLEN      = 64,
   parameter int IMM_W     = 16,
   parameter int IMM_SHIFT = 16,
   parameter int BYTE_W    = 8
) (
   input  logic [XLEN-1:0]  rs_i,
   input  logic [XLEN-1:0]  rb_i,
   input  logic [IMM_W-1:0] imm_i,
   input  logic [OP_W-1:0]  op_i,
   input  logic             rec_i,
   output logic [XLEN-1:0]  res_o,
   output logic [2:0]       flags_o
);

   localparam int N_EXT   = 3;
   localparam int WIDEST  = BYTE_W << (N_EXT - 1);

   if (XLEN < IMM_SHIFT + IMM_W) begin : g_bad_imm
      $error("logic_sext_unit: shifted immediate does not fit in XLEN");
   end
   if (WIDEST >= XLEN) begin : g_bad_ext
      $error("logic_sext_unit: widest sign-extend source must be narrower than XLEN");
   end

   ctrl_t ctrl;

   always_comb begin
      ctrl = '{kind: KIND_NONE, base: BASE_AND, src: SRC_REG,
               inv_b: 1'b0, inv_out: 1'b0, ext_sel: 2'd0};
      case (op_i)
         OP_AND:   begin ctrl.kind = KIND_LOGIC; ctrl.base = BASE_AND; end
         OP_OR:    begin ctrl.kind = KIND_LOGIC; ctrl.base = BASE_OR;  end
         OP_XOR:   begin ctrl.kind = KIND_LOGIC; ctrl.base = BASE_XOR; end
         OP_NAND:  begin ctrl.kind = KIND_LOGIC; ctrl.base = BASE_AND; ctrl.inv_out = 1'b1; end
         OP_NOR:   begin ctrl.kind = KIND_LOGIC; ctrl.base = BASE_OR;  ctrl.inv_out = 1'b1; end
         OP_EQV:   begin ctrl.kind = KIND_LOGIC; ctrl.base = BASE_XOR; ctrl.inv_out = 1'b1; end
         OP_ANDC:  begin ctrl.kind = KIND_LOGIC; ctrl.base = BASE_AND; ctrl.inv_b = 1'b1; end
         OP_ORC:   begin ctrl.kind = KIND_LOGIC; ctrl.base = BASE_OR;  ctrl.inv_b = 1'b1; end
         OP_ANDLO: begin ctrl.kind = KIND_LOGIC; ctrl.base = BASE_AND; ctrl.src = SRC_IMMLO; end
         OP_ORLO:  begin ctrl.kind = KIND_LOGIC; ctrl.base = BASE_OR;  ctrl.src = SRC_IMMLO; end
         OP_XORLO: begin ctrl.kind = KIND_LOGIC; ctrl.base = BASE_XOR; ctrl.src = SRC_IMMLO; end
         OP_ANDHI: begin ctrl.kind = KIND_LOGIC; ctrl.base = BASE_AND; ctrl.src = SRC_IMMHI; end
         OP_ORHI:  begin ctrl.kind = KIND_LOGIC; ctrl.base = BASE_OR;  ctrl.src = SRC_IMMHI; end
         OP_XORHI: begin ctrl.kind = KIND_LOGIC; ctrl.base = BASE_XOR; ctrl.src = SRC_IMMHI; end
         OP_SXB:   begin ctrl.kind = KIND_EXT;   ctrl.ext_sel = 2'd0; end
         OP_SXH:   begin ctrl.kind = KIND_EXT;   ctrl.ext_sel = 2'd1; end
         OP_SXW:   begin ctrl.kind = KIND_EXT;   ctrl.ext_sel = 2'd2; end
         default:  ctrl.kind = KIND_NONE;
      endcase
   end

   logic [XLEN-1:0] imm_lo;
   logic [XLEN-1:0] imm_hi;
   logic [XLEN-1:0] opnd_b;

   assign imm_lo = XLEN'(imm_i);
   assign imm_hi = imm_lo << IMM_SHIFT;

   always_comb begin
      unique case (ctrl.src)
         SRC_IMMLO: opnd_b = imm_lo;
         SRC_IMMHI: opnd_b = imm_hi;
         default:   opnd_b = rb_i;
      endcase
   end

   logic [XLEN-1:0] bool_res;

   lsx_bool #(.XLEN(XLEN)) u_bool (
      .a_i       (rs_i),
      .b_i       (opnd_b),
      .base_i    (ctrl.base),
      .inv_b_i   (ctrl.inv_b),
      .inv_out_i (ctrl.inv_out),
      .y_o       (bool_res)
   );

   logic [XLEN-1:0] ext_res [N_EXT];

   for (genvar k = 0; k < N_EXT; k++) begin : g_ext
      localparam int FW = BYTE_W << k;
      lsx_sext #(.XLEN(XLEN), .FROM_W(FW)) u_sext (
         .src_i (rs_i[FW-1:0]),
         .y_o   (ext_res[k])
      );
   end

   logic [XLEN-1:0] ext_pick;

   always_comb begin
      case (ctrl.ext_sel)
         2'd0:    ext_pick = ext_res[0];
         2'd1:    ext_pick = ext_res[1];
         default: ext_pick = ext_res[2];
      endcase
   end

   always_comb begin
      unique case (ctrl.kind)
         KIND_LOGIC: res_o = bool_res;
         KIND_EXT:   res_o = ext_pick;
         default:    res_o = '0;
      endcase
   end

   lsx_flags #(.XLEN(XLEN)) u_flags (
      .res_i   (res_o),
      .rec_i   (rec_i),
      .flags_o (flags_o)
   );

endmodule

// File: rtl/logic_sext_unit_chk.sv
module logic_sext_unit_chk #(
   parameter int XLEN = 64
) (
   input logic [XLEN-1:0] res_o,
   input logic [4:0]      op_i,
   input logic            rec_i,
   input logic [2:0]      flags_o
);

   always_comb begin
      if (rec_i) begin
         AST_REC_ONEHOT: assert ($onehot(flags_o)) else $error("record flags not one-hot"); // R8
      end
      if (!rec_i) begin
         AST_NOREC_CLEAR: assert (flags_o == 3'b000) else $error("flags set without record"); // R9
      end
      if (flags_o[0]) begin
         AST_EQ_MEANS_ZERO: assert (res_o == '0) else $error("EQ with nonzero result"); // R8
      end
      if (flags_o[2]) begin
         AST_LT_MEANS_NEG: assert (res_o[XLEN-1]) else $error("LT with nonnegative result"); // R8
      end
      if (op_i == 5'd8) begin
         AST_ANDLO_UPPER_CLEAR: assert (res_o[XLEN-1:16] == '0) else $error("AND immediate leaked upper bits"); // R4
      end
      if (op_i == 5'd16) begin
         AST_SXW_UPPER_FILL: assert (res_o[XLEN-1:32] == {(XLEN-32){res_o[31]}}) else $error("word extend fill wrong"); // R6
      end
      if (op_i > 5'd16) begin
         AST_UNUSED_CODE_ZERO: assert (res_o == '0) else $error("unassigned code gave nonzero"); // R7
      end
   end

endmodule

bind logic_sext_unit logic_sext_unit_chk #(.XLEN(XLEN)) u_chk (
   .res_o   (res_o),
   .op_i    (op_i),
   .rec_i   (rec_i),
   .flags_o (flags_o)
);

// File: tb/logic_sext_unit_tb_top.sv
`timescale 1ns/1ps
module logic_sext_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] rs, rb;
   logic [15:0] imm;
   logic [4:0]  op;
   logic        rec;
   logic [63:0] res;
   logic [2:0]  flags;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   logic_sext_unit dut_i (
      .rs_i    (rs),
      .rb_i    (rb),
      .imm_i   (imm),
      .op_i    (op),
      .rec_i   (rec),
      .res_o   (res),
      .flags_o (flags)
   );

   function automatic logic [63:0] model(input int code, input logic [63:0] a,
                                         input logic [63:0] b, input logic [15:0] k);
      logic [63:0] lo = {48'h0, k};
      logic [63:0] hi = {32'h0, k, 16'h0};
      case (code)
         0:  return a & b;
         1:  return a | b;
         2:  return a ^ b;
         3:  return ~(a & b);
         4:  return ~(a | b);
         5:  return ~(a ^ b);
         6:  return a & ~b;
         7:  return a | ~b;
         8:  return a & lo;
         9:  return a | lo;
         10: return a ^ lo;
         11: return a & hi;
         12: return a | hi;
         13: return a ^ hi;
         14: return {{56{a[7]}}, a[7:0]};
         15: return {{48{a[15]}}, a[15:0]};
         16: return {{32{a[31]}}, a[31:0]};
         default: return 64'h0;
      endcase
   endfunction

   function automatic string tag_of(input int code);
      if (code <= 2)  return "R1";
      if (code <= 5)  return "R2";
      if (code <= 7)  return "R3";
      if (code <= 10) return "R4";
      if (code <= 13) return "R5";
      if (code <= 16) return "R6";
      return "R7";
   endfunction

   task automatic apply(input int code, input logic [63:0] a, input logic [63:0] b,
                        input logic [15:0] k, input logic r);
      logic [63:0] e;
      logic [2:0]  ef;
      @(negedge clk);
      op = code[4:0]; rs = a; rb = b; imm = k; rec = r;
      #2;
      e = model(code, a, b, k);
      if (r) ef = {$signed(e) < 0, $signed(e) > 0, e == 64'h0};
      else   ef = 3'b000;
      n_chk++;
      if (res !== e) begin
         n_bad++;
         $display("FAIL %s op=%0d result act=%h exp=%h", tag_of(code), code, res, e);
      end
      n_chk++;
      if (flags !== ef) begin
         n_bad++;
         $display("FAIL %s op=%0d flags act=%b exp=%b", r ? "R8" : "R9", code, flags, ef);
      end
   endtask

   logic [63:0] corner [8];

   initial begin
      corner[0] = 64'h0;
      corner[1] = '1;
      corner[2] = 64'h5555_5555_5555_5555;
      corner[3] = 64'hAAAA_AAAA_AAAA_AAAA;
      corner[4] = 64'h8000_0000_0000_0000;
      corner[5] = 64'h0000_0000_8000_8080;
      corner[6] = 64'hFFFF_FFFF_7FFF_7F7F;
      corner[7] = 64'h0000_0000_0000_0001;
      rs = '0; rb = '0; imm = '0; op = '0; rec = 1'b0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // Reset-state style check: code 0 with zero operands, no record (R1, R9)
      apply(0, 64'h0, 64'h0, 16'h0, 1'b0);
      // Corner sweep over every code, record flag alternating (R1..R9)
      for (int c = 0; c < 32; c++) begin
         for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
               apply(c, corner[i], corner[j], corner[j][31:16] ^ corner[i][15:0],
                     1'((c + i + j) & 1));
            end
         end
      end
      // Random operands across every code (R1..R9)
      for (int n = 0; n < 200; n++) begin
         for (int c = 0; c < 32; c++) begin
            apply(c, {$urandom, $urandom}, {$urandom, $urandom}, 16'($urandom),
                  1'($urandom & 1));
         end
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #1_500_000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule